// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an I2C host read and write a bank of byte-wide control and status registers that sit outside the block. It samples the open-drain clock and data lines with the faster system clock and recognises START and STOP conditions. It accepts a 7-bit device address whose two low bits are set by two strap pins. After a matching write address it takes one register index byte and then any number of data bytes. It issues a one-cycle write strobe for each data byte.

A read happens in two transactions. First a write transaction carries only the index and ends with STOP. Then a new transaction carries the read address, and the slave returns one byte taken from the register side. The stored index is kept across STOP, so any later read returns the register at that index. The block only ever pulls the data line low: an output of 1 means "drive SDA low", and the pad or board supplies the open-drain release.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) starts address reception from any state. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released. Bits clocked after a STOP without a new START are ignored.
- R2: The device address is 7 bits: binary 10011 followed by `addr_sel[1]` and `addr_sel[0]`. The address byte carries this address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). This gives write bytes 98h/9Ah/9Ch/9Eh and read bytes 99h/9Bh/9Dh/9Fh for `addr_sel` 0..3. On a match the slave pulls SDA low during the ninth clock.
- R3: On an address byte that does not match, the slave does not acknowledge. It drives nothing, issues no strobe and leaves the index unchanged until the next START.
- R4: The first byte after a write address is acknowledged and stored as the register index. The index is presented on `reg_idx`, which is 0 after reset.
- R5: Each further byte in a write transaction is acknowledged. It produces exactly one `reg_wr` pulse of one cycle, with `reg_wdata` equal to the byte and `reg_idx` equal to the stored index. The index does not advance between bytes.
- R6: After an acknowledged read address, the slave returns the value of `reg_rdata` MSB first. It captures that value at the SCL fall that ends the address acknowledge, and it changes SDA only while SCL is low.
- R7: After the eight read bits the slave releases SDA. It drives nothing further until the next START, whether the host answers with ACK or NACK.
- R8: The stored index survives STOP and non-matching transactions. A read transaction returns the register at the index set by the last write transaction.
- R9: A START that arrives partway through a byte discards the partial byte, issues no strobe, and begins a new address phase.
- R10: While `rst_n` is low at a clock edge, the slave releases SDA, holds `reg_wr` low and clears `reg_idx` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sensed level of the I2C clock line |
| sda_in | input | 1 | Sensed level of the I2C data line |
| addr_sel | input | 2 | Strap pins giving the two low device-address bits |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_idx | output | 8 | Stored register index |
| reg_wdata | output | 8 | Data byte to write |
| reg_rdata | input | 8 | Register value at `reg_idx`, returned on reads |

## Verification
The START detector and the bit shifter both update the same state, bit counter and shift register. A START has to win whenever it arrives while a byte is partly shifted in. The bench provokes this by clocking four data bits of a write byte and then issuing a repeated START in place of the fifth bit, followed by a complete new transaction to a different index. The result is judged at the register side: exactly one write strobe must appear, carrying the second transaction's index and data. No strobe may come from the abandoned byte.

// File: rtl/i2c_regs_pkg.sv
// Package: shared types for the I2C register-access slave.
// Assumes one byte width for index and data; the address is one bit narrower.
package i2c_regs_pkg;

    // Protocol controller states
    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until START
        ST_RX,     // shifting in a byte from the host
        ST_ACKW,   // byte taken, waiting for SCL low to pull SDA
        ST_ACK,    // holding SDA low through the acknowledge clock
        ST_TX,     // shifting read data out
        ST_MACK    // host acknowledge clock after read data
    } slv_state_t;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_DATA
    } rx_phase_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
// Module: i2c_bus_sampler
// Brings SCL and SDA into the clock domain through SYNC_STAGES flops. It
// keeps one extra history flop and derives SCL edges and START/STOP events
// from it. Assumes SCL is slow enough that every level lasts several clocks.
module i2c_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer plus history stage; bus lines idle high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
        end
    end

    assign scl_lvl  = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl  = sda_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    // Edge and bus-condition decode from present and previous levels
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/i2c_slave_ctrl.sv
// Module: i2c_slave_ctrl
// Byte-level protocol engine. It matches the address, stores the index,
// strobes writes and shifts out read data. Assumes its inputs come from
// i2c_bus_sampler. The data line is only ever pulled low, and only after an
// SCL fall has been seen.
module i2c_slave_ctrl
    import i2c_regs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-2:0] dev_addr,
    output logic              sda_pull,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_idx,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int              CNT_W    = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    slv_state_t        state;
    rx_phase_t         phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rx_byte;
    logic              rd_mode;

    // Byte as it stands once the current sampled bit is included
    assign rx_byte = {shreg[BYTE_W-2:0], sda_lvl};

    // Protocol sequencing; bus conditions take priority over bit activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_ADDR;
            bit_cnt   <= '0;
            shreg     <= '0;
            rd_mode   <= 1'b0;
            sda_pull  <= 1'b0;
            reg_wr    <= 1'b0;
            reg_idx   <= '0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            if (start_det) begin
                state    <= ST_RX;
                phase    <= PH_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                case (phase)
                                    PH_ADDR: begin
                                        if (rx_byte[BYTE_W-1:1] == dev_addr) begin
                                            rd_mode <= rx_byte[0];
                                            state   <= ST_ACKW;
                                        end else begin
                                            state <= ST_IDLE;
                                        end
                                    end
                                    PH_INDEX: begin
                                        reg_idx <= rx_byte;
                                        state   <= ST_ACKW;
                                    end
                                    default: begin
                                        reg_wdata <= rx_byte;
                                        reg_wr    <= 1'b1;
                                        state     <= ST_ACKW;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACKW: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (phase == PH_ADDR && rd_mode) begin
                                shreg    <= reg_rdata;
                                sda_pull <= ~reg_rdata[BYTE_W-1];
                                bit_cnt  <= '0;
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_RX;
                                phase    <= (phase == PH_ADDR) ? PH_INDEX : PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == ALL_BITS) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: the slave moves SDA only while SCL is low, except for a release forced by a bus condition
    a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

    // R3: an idle slave never holds the line
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    // R1: a STOP always lands in idle
    a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> (state == ST_IDLE));

    // R1: a START always opens address reception
    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && phase == PH_ADDR));

    // R5: the write strobe lasts one cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5: the index is settled while a write is strobed
    a_r5_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $stable(reg_idx));

    // R7: during the host acknowledge after read data, the line is free
    a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !sda_pull);

endmodule

// File: rtl/i2c_reg_slave.sv
// Module: i2c_reg_slave (top)
// I2C slave that reaches a byte-wide register bank. Two strap pins set the
// low address bits. Assumes open-drain lines: sda_pull = 1 pulls SDA low.
// reg_rdata must reflect the register at reg_idx.
module i2c_reg_slave #(
    parameter int                  BYTE_W      = 8,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [BYTE_W-4:0]   ADDR_HI     = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [1:0]        addr_sel,
    output logic              sda_pull,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_idx,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-2:0] dev_addr;

    // Full device address: fixed high part, strapped low bits
    assign dev_addr = {ADDR_HI, addr_sel};

    i2c_bus_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_slave_ctrl #(
        .BYTE_W(BYTE_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .dev_addr (dev_addr),
        .sda_pull (sda_pull),
        .reg_wr   (reg_wr),
        .reg_idx  (reg_idx),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
    localparam int Q = 8;  // clocks per quarter SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic       sda_pull;
    logic       reg_wr;
    logic [7:0] reg_idx;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    wire        sda_line = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    i2c_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .sda_pull(sda_pull), .reg_wr(reg_wr),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register bank model on the register side
    logic [7:0] regs [256];
    int         wr_cnt = 0;
    logic [7:0] last_idx = 8'h00;
    logic [7:0] last_data = 8'h00;
    assign reg_rdata = regs[reg_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'hA5;
        end else if (reg_wr) begin
            regs[reg_idx] <= reg_wdata;
            wr_cnt    <= wr_cnt + 1;
            last_idx  <= reg_idx;
            last_data <= reg_wdata;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b, output logic steady);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_line; wait_q();
        steady = (sda_line == b);
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a, s;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a, s);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] v, output logic steady);
        logic b, s;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, s);
            v[i] = b;
            steady = steady & s;
        end
        put_bit(~host_ack);
    endtask

    // Clocks n bits with the host releasing SDA; returns 1 if the line stayed high
    task automatic idle_bits(input int n, output logic all_high);
        logic b, s;
        all_high = 1'b1;
        for (int i = 0; i < n; i++) begin
            get_bit(b, s);
            all_high = all_high & b & s;
        end
    endtask

    // Stimulus table: {strap, index, data}
    localparam logic [17:0] VECS [5] = '{
        {2'd0, 8'h0F, 8'hF0},
        {2'd1, 8'h55, 8'h3C},
        {2'd2, 8'hA0, 8'h81},
        {2'd3, 8'hFF, 8'h7E},
        {2'd0, 8'h00, 8'h01}
    };

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic       ack, steady, quiet;
        logic [7:0] rd;
        int         base;

        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 sda_pull in reset", 32'(sda_pull), 0);
        chk("R10 reg_wr in reset", 32'(reg_wr), 0);
        rst_n = 1'b1;
        wait_q();
        chk("R10 reg_idx after reset", 32'(reg_idx), 0);

        // Table walk: write, then read back using the persisting index
        for (int v = 0; v < 5; v++) begin
            logic [1:0] sel;
            logic [7:0] idx, dat, wa;
            {sel, idx, dat} = VECS[v];
            addr_sel = sel;
            wa = {5'b10011, sel, 1'b0};
            base = wr_cnt;
            bus_start();
            send_byte(wa, ack);   chk("R2 write address ack", 32'(ack), 1);
            send_byte(idx, ack);  chk("R4 index ack", 32'(ack), 1);
            send_byte(dat, ack);  chk("R5 data ack", 32'(ack), 1);
            bus_stop();
            chk("R1 released after STOP", 32'(sda_pull), 0);
            chk("R5 strobe count", 32'(wr_cnt - base), 1);
            chk("R5 strobe index", 32'(last_idx), 32'(idx));
            chk("R5 strobe data", 32'(last_data), 32'(dat));
            chk("R4 reg_idx holds index", 32'(reg_idx), 32'(idx));
            bus_start();
            send_byte(wa | 8'h01, ack); chk("R2 read address ack", 32'(ack), 1);
            recv_byte(1'b0, rd, steady);
            chk("R6 read data", 32'(rd), 32'(dat));
            chk("R6 SDA steady while SCL high", 32'(steady), 1);
            idle_bits(3, quiet);
            chk("R7 released after NACK", 32'(quiet), 1);
            bus_stop();
        end

        // R3: wrong write address gets no ACK, later bytes ignored
        addr_sel = 2'd0;
        base = wr_cnt;
        bus_start();
        send_byte(8'h9A, ack); chk("R3 mismatched address nack", 32'(ack), 0);
        send_byte(8'h12, ack); chk("R3 index ignored nack", 32'(ack), 0);
        send_byte(8'h34, ack); chk("R3 data ignored nack", 32'(ack), 0);
        bus_stop();
        chk("R3 no strobe after mismatch", 32'(wr_cnt - base), 0);
        chk("R3 index untouched", 32'(reg_idx), 32'h00);

        // R3: wrong read address drives nothing
        bus_start();
        send_byte(8'h9F, ack); chk("R3 mismatched read nack", 32'(ack), 0);
        idle_bits(9, quiet);   chk("R3 no read data driven", 32'(quiet), 1);
        bus_stop();

        // R8: index set by its own transaction survives STOP and a foreign transaction
        bus_start();
        send_byte(8'h98, ack); send_byte(8'h33, ack);
        bus_stop();
        bus_start();
        send_byte(8'h9C, ack);
        bus_stop();
        bus_start();
        send_byte(8'h99, ack); chk("R8 read ack", 32'(ack), 1);
        recv_byte(1'b0, rd, steady);
        bus_stop();
        chk("R8 read at stored index", 32'(rd), 32'(8'h33 ^ 8'hA5));

        // R5: two data bytes both land on the same index
        base = wr_cnt;
        bus_start();
        send_byte(8'h98, ack); send_byte(8'h20, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack);
        chk("R5 second data ack", 32'(ack), 1);
        bus_stop();
        chk("R5 two strobes", 32'(wr_cnt - base), 2);
        chk("R5 index not advanced", 32'(last_idx), 32'h20);
        chk("R5 last data", 32'(last_data), 32'h22);

        // R7: host ACK after the byte still gets no second byte
        bus_start();
        send_byte(8'h99, ack);
        recv_byte(1'b1, rd, steady);
        chk("R6 read after multi-byte write", 32'(rd), 32'h22);
        idle_bits(9, quiet);
        chk("R7 released after host ACK", 32'(quiet), 1);
        bus_stop();

        // R9: repeated START inside a data byte discards it
        base = wr_cnt;
        bus_start();
        send_byte(8'h98, ack); send_byte(8'h44, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(8'h98, ack); chk("R9 address after restart", 32'(ack), 1);
        send_byte(8'h45, ack); send_byte(8'h99, ack);
        bus_stop();
        chk("R9 single strobe", 32'(wr_cnt - base), 1);
        chk("R9 strobe index", 32'(last_idx), 32'h45);
        chk("R9 strobe data", 32'(last_data), 32'h99);

        // R1: STOP mid-address, then bits without START are ignored
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        scl_m = 1'b0; wait_q();
        send_byte(8'h98, ack);
        chk("R1 no ack without START", 32'(ack), 0);
        bus_stop();

        finish_run();
    end

endmodule